// File: doc/BRIEF.md
# Host-to-controller command mailbox

This block is the register window through which a host processor hands commands to an embedded controller and collects the results. The host sees a 256-byte window on a simple 32-bit register bus. A write to the command register rings a doorbell toward the controller and marks the mailbox busy. The controller then reads the latched command word and the payload the host placed in the write buffer. It does its work, fills the read buffer with response words, and pulses a done strobe carrying a fail flag, an error code and an initiator tag.

The host polls the status register until busy clears and then inspects the error bit and the error code. If the command word asked for it, the host also receives a single-cycle completion pulse that needs no acknowledgement. While a command is in flight, the command word and payload the controller is reading are protected. A second command or a payload write from the host cannot disturb them. A second command is instead recorded as an overrun.

Host accesses take one cycle: `hst_valid` qualifies `hst_write`, `hst_addr`, `hst_be` and `hst_wdata`. Read data appears on `hst_rdata` one cycle after the request.

Top module: `hc_mailbox`

## Requirements
- R1: After reset, busy, error and overrun are 0, the status word reads 0x00000000, `ctl_doorbell` and `host_irq` are 0, and `ctl_cmd` and `ctl_wbuf` are all zeros.
- R2: A host write to offset 0x00 while idle latches the full 32-bit word onto `ctl_cmd` (byte enables are ignored for this register). Busy (status bit 0) is set on that same edge, and `ctl_doorbell` is 1 for exactly the following cycle.
- R3: A command write while busy leaves `ctl_cmd` and the busy state unchanged, gives no doorbell, and sets the overrun bit (status bit 2). The overrun bit stays set until reset.
- R4: A `ctl_done` pulse while busy clears busy. On the same edge it loads the error bit (status bit 1) from `ctl_fail`, the error code (status bits 23:16) from `ctl_ecode`, and the initiator field (status bits 15:8) from `ctl_initiator`. A `ctl_done` pulse while idle changes nothing.
- R5: Status bits 7:4 echo bits 15:12 of the most recently accepted command, and bits 3 and 31:24 read 0. Accepting a command clears the error bit and the error code but keeps the initiator field.
- R6: When bit 8 of the accepted command is 1, the edge that completes it raises `host_irq` for exactly one cycle. When bit 8 is 0, completion raises no `host_irq`.
- R7: Host writes to offsets 0x80 to 0x8F store the enabled bytes of `hst_wdata` (lane b from `hst_be[b]`) little-endian, so buffer byte k appears on `ctl_wbuf[8k+7:8k]`. Such writes are dropped while busy.
- R8: A `ctl_resp_we` pulse stores `ctl_resp_data` as read-buffer word `ctl_resp_idx` (bytes 4i to 4i+3). A host read at offset 0x90+n returns the word holding byte n shifted right by 8*(n mod 4), which places byte n in bits 7:0.
- R9: Host reads of the command register, the write buffer and unmapped offsets return 0. Host writes to the status register, the read buffer and unmapped offsets have no effect.
- R10: Read data appears on `hst_rdata` in the cycle after the read request and holds until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| hst_valid | input | 1 | Host access this cycle |
| hst_write | input | 1 | 1 = write, 0 = read |
| hst_addr | input | ADDR_W | Byte offset in the window |
| hst_be | input | 4 | Byte enables for write-buffer writes |
| hst_wdata | input | 32 | Host write data |
| hst_rdata | output | 32 | Registered host read data |
| host_irq | output | 1 | One-cycle completion pulse to the host |
| ctl_doorbell | output | 1 | One-cycle new-command pulse to the controller |
| ctl_cmd | output | 32 | Latched command word |
| ctl_wbuf | output | BUF_BYTES*8 | Write-buffer contents, byte k at bits 8k+7:8k |
| ctl_done | input | 1 | Controller completion strobe |
| ctl_fail | input | 1 | Completion failed |
| ctl_ecode | input | 8 | Error code reported with completion |
| ctl_initiator | input | 8 | Initiator tag reported with completion |
| ctl_resp_we | input | 1 | Store a read-buffer word |
| ctl_resp_idx | input | IDX_W | Read-buffer word index |
| ctl_resp_data | input | 32 | Read-buffer word data |

## Verification
The assertions assume that the controller drives `ctl_done` as a single-cycle strobe, and only after it has seen a doorbell. Without that assumption, the one-shot completion pulse and the busy-clearing checks would say nothing useful. The bench only pulses done after issuing a command, with one exception: it sends one deliberate done while idle, to show that such a pulse is ignored. The stimulus holds every host access and every controller strobe for exactly one cycle, and drives them on the falling edge. This keeps each request to one accepted transaction. Back-to-back commands are issued on purpose while busy, so that the overrun path and the frozen command and payload are exercised.

// File: rtl/mbox_pkg.sv
package mbox_pkg;

    localparam int WORD_W = 32;

    // window offsets
    localparam logic [7:0] OFS_CMD  = 8'h00;
    localparam logic [7:0] OFS_STAT = 8'h04;
    localparam logic [7:0] OFS_WBUF = 8'h80;
    localparam logic [7:0] OFS_RBUF = 8'h90;

    // command word fields
    localparam int CMD_IOC_BIT = 8;
    localparam int CMD_SUB_LSB = 12;

    typedef enum logic [2:0] {
        RG_NONE,
        RG_CMD,
        RG_STAT,
        RG_WBUF,
        RG_RBUF
    } region_e;

    typedef struct packed {
        logic              busy;
        logic              err;
        logic              ovr;
        logic              ioc;
        logic              bell;
        logic              irq;
        logic [WORD_W-1:0] cmd;
        logic [7:0]        init;
        logic [7:0]        ecode;
    } ctrl_st_t;

endpackage

// File: rtl/mbox_regdec.sv
module mbox_regdec
    import mbox_pkg::*;
#(
    parameter int ADDR_W    = 8,
    parameter int BUF_BYTES = 16,
    localparam int BUF_WORDS = BUF_BYTES / 4,
    localparam int IDX_W     = $clog2(BUF_WORDS)
) (
    input  logic [ADDR_W-1:0] addr,
    output region_e           region,
    output logic [IDX_W-1:0]  word_idx,
    output logic [1:0]        lane
);

    localparam logic [ADDR_W-1:0] A_CMD  = ADDR_W'(OFS_CMD);
    localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(OFS_STAT);
    localparam logic [ADDR_W-1:0] A_WB   = ADDR_W'(OFS_WBUF);
    localparam logic [ADDR_W-1:0] A_WE   = ADDR_W'(int'(OFS_WBUF) + BUF_BYTES);
    localparam logic [ADDR_W-1:0] A_RB   = ADDR_W'(OFS_RBUF);
    localparam logic [ADDR_W-1:0] A_RE   = ADDR_W'(int'(OFS_RBUF) + BUF_BYTES);

    logic [ADDR_W-1:0] off_w;
    logic [ADDR_W-1:0] off_r;

    always_comb begin
        off_w    = addr - A_WB;
        off_r    = addr - A_RB;
        lane     = addr[1:0];
        region   = RG_NONE;
        word_idx = off_w[IDX_W+1:2];
        if (addr[ADDR_W-1:2] == A_CMD[ADDR_W-1:2]) begin
            region = RG_CMD;
        end else if (addr[ADDR_W-1:2] == A_STAT[ADDR_W-1:2]) begin
            region = RG_STAT;
        end else if (addr >= A_WB && addr < A_WE) begin
            region = RG_WBUF;
        end else if (addr >= A_RB && addr < A_RE) begin
            region   = RG_RBUF;
            word_idx = off_r[IDX_W+1:2];
        end
    end

endmodule

// File: rtl/mbox_wbuf.sv
module mbox_wbuf #(
    parameter int BUF_BYTES = 16,
    localparam int BUF_WORDS = BUF_BYTES / 4,
    localparam int IDX_W     = $clog2(BUF_WORDS)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   we,
    input  logic [IDX_W-1:0]       word_idx,
    input  logic [3:0]             be,
    input  logic [31:0]            wdata,
    output logic [BUF_BYTES*8-1:0] bytes_o
);

    logic [BUF_BYTES-1:0]   byte_we;
    logic [BUF_BYTES*8-1:0] data_d, data_q;

    // one enable per stored byte
    for (genvar k = 0; k < BUF_BYTES; k++) begin : g_byte
        assign byte_we[k] = we && (word_idx == IDX_W'(k / 4)) && be[k % 4];
    end

    always_comb begin
        data_d = data_q;
        for (int k = 0; k < BUF_BYTES; k++) begin
            if (byte_we[k]) begin
                data_d[k*8 +: 8] = wdata[(k % 4)*8 +: 8];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) data_q <= '0;
        else        data_q <= data_d;
    end

    assign bytes_o = data_q;

endmodule

// File: rtl/mbox_rbuf.sv
module mbox_rbuf #(
    parameter int BUF_BYTES = 16,
    localparam int BUF_WORDS = BUF_BYTES / 4,
    localparam int IDX_W     = $clog2(BUF_WORDS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [31:0]      wdata,
    input  logic [IDX_W-1:0] rd_idx,
    input  logic [1:0]       rd_lane,
    output logic [31:0]      rd_word
);

    logic [BUF_WORDS-1:0]       word_we;
    logic [BUF_WORDS-1:0][31:0] mem_d, mem_q;

    for (genvar w = 0; w < BUF_WORDS; w++) begin : g_word
        assign word_we[w] = we && (wr_idx == IDX_W'(w));
    end

    always_comb begin
        mem_d = mem_q;
        for (int w = 0; w < BUF_WORDS; w++) begin
            if (word_we[w]) mem_d[w] = wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) mem_q <= '0;
        else        mem_q <= mem_d;
    end

    // addressed byte lands in bits 7:0
    assign rd_word = mem_q[rd_idx] >> {rd_lane, 3'b000};

endmodule

// File: rtl/mbox_ctrl.sv
module mbox_ctrl
    import mbox_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_wr,
    input  logic [WORD_W-1:0] cmd_in,
    input  logic              done,
    input  logic              fail,
    input  logic [7:0]        ecode_in,
    input  logic [7:0]        init_in,
    output logic              busy,
    output logic              bell,
    output logic              irq,
    output logic [WORD_W-1:0] cmd_o,
    output logic [WORD_W-1:0] status
);

    ctrl_st_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.bell = 1'b0;
        st_d.irq  = 1'b0;
        if (done && st_q.busy) begin
            st_d.busy  = 1'b0;
            st_d.err   = fail;
            st_d.ecode = ecode_in;
            st_d.init  = init_in;
            st_d.irq   = st_q.ioc;
        end
        if (cmd_wr) begin
            if (st_q.busy) begin
                st_d.ovr = 1'b1;
            end else begin
                st_d.busy  = 1'b1;
                st_d.bell  = 1'b1;
                st_d.cmd   = cmd_in;
                st_d.ioc   = cmd_in[CMD_IOC_BIT];
                st_d.err   = 1'b0;
                st_d.ecode = '0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign busy   = st_q.busy;
    assign bell   = st_q.bell;
    assign irq    = st_q.irq;
    assign cmd_o  = st_q.cmd;
    assign status = {8'h00, st_q.ecode, st_q.init,
                     st_q.cmd[CMD_SUB_LSB +: 4], 1'b0, st_q.ovr, st_q.err, st_q.busy};

endmodule

// File: rtl/hc_mailbox.sv
module hc_mailbox
    import mbox_pkg::*;
#(
    parameter int ADDR_W    = 8,
    parameter int BUF_BYTES = 16,
    localparam int BUF_WORDS = BUF_BYTES / 4,
    localparam int IDX_W     = $clog2(BUF_WORDS)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   hst_valid,
    input  logic                   hst_write,
    input  logic [ADDR_W-1:0]      hst_addr,
    input  logic [3:0]             hst_be,
    input  logic [31:0]            hst_wdata,
    output logic [31:0]            hst_rdata,
    output logic                   host_irq,
    output logic                   ctl_doorbell,
    output logic [31:0]            ctl_cmd,
    output logic [BUF_BYTES*8-1:0] ctl_wbuf,
    input  logic                   ctl_done,
    input  logic                   ctl_fail,
    input  logic [7:0]             ctl_ecode,
    input  logic [7:0]             ctl_initiator,
    input  logic                   ctl_resp_we,
    input  logic [IDX_W-1:0]       ctl_resp_idx,
    input  logic [31:0]            ctl_resp_data
);

    region_e          region;
    logic [IDX_W-1:0] word_idx;
    logic [1:0]       lane;
    logic             busy;
    logic [31:0]      status;
    logic [31:0]      rbuf_word;
    logic             wr_cmd, wr_wbuf, rd_req;
    logic [31:0]      rdata_d, rdata_q;

    mbox_regdec #(.ADDR_W(ADDR_W), .BUF_BYTES(BUF_BYTES)) u_dec (
        .addr     (hst_addr),
        .region   (region),
        .word_idx (word_idx),
        .lane     (lane)
    );

    assign wr_cmd  = hst_valid && hst_write && (region == RG_CMD);
    assign wr_wbuf = hst_valid && hst_write && (region == RG_WBUF) && !busy;
    assign rd_req  = hst_valid && !hst_write;

    mbox_ctrl u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .cmd_wr   (wr_cmd),
        .cmd_in   (hst_wdata),
        .done     (ctl_done),
        .fail     (ctl_fail),
        .ecode_in (ctl_ecode),
        .init_in  (ctl_initiator),
        .busy     (busy),
        .bell     (ctl_doorbell),
        .irq      (host_irq),
        .cmd_o    (ctl_cmd),
        .status   (status)
    );

    mbox_wbuf #(.BUF_BYTES(BUF_BYTES)) u_wbuf (
        .clk      (clk),
        .rst_n    (rst_n),
        .we       (wr_wbuf),
        .word_idx (word_idx),
        .be       (hst_be),
        .wdata    (hst_wdata),
        .bytes_o  (ctl_wbuf)
    );

    mbox_rbuf #(.BUF_BYTES(BUF_BYTES)) u_rbuf (
        .clk     (clk),
        .rst_n   (rst_n),
        .we      (ctl_resp_we),
        .wr_idx  (ctl_resp_idx),
        .wdata   (ctl_resp_data),
        .rd_idx  (word_idx),
        .rd_lane (lane),
        .rd_word (rbuf_word)
    );

    always_comb begin
        rdata_d = rdata_q;
        if (rd_req) begin
            unique case (region)
                RG_STAT: rdata_d = status;
                RG_RBUF: rdata_d = rbuf_word;
                default: rdata_d = '0;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) rdata_q <= '0;
        else        rdata_q <= rdata_d;
    end

    assign hst_rdata = rdata_q;

endmodule

// File: rtl/mbox_chk.sv
module mbox_chk #(
    parameter int BUF_BYTES = 16
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   busy,
    input logic                   ctl_doorbell,
    input logic                   ctl_done,
    input logic                   host_irq,
    input logic [31:0]            ctl_cmd,
    input logic [BUF_BYTES*8-1:0] ctl_wbuf
);

    AST_BELL_ONE_SHOT: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_doorbell |=> !ctl_doorbell); // R2

    AST_BELL_MEANS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_doorbell |-> busy); // R2

    AST_CMD_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !ctl_doorbell) |-> $stable(ctl_cmd)); // R3

    AST_DONE_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_done && busy) |=> !busy); // R4

    AST_IRQ_AFTER_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        host_irq |-> !busy); // R6

    AST_IRQ_ONE_SHOT: assert property (@(posedge clk) disable iff (!rst_n)
        host_irq |=> !host_irq); // R6

    AST_WBUF_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !ctl_doorbell) |-> $stable(ctl_wbuf)); // R7

endmodule

bind hc_mailbox mbox_chk #(.BUF_BYTES(BUF_BYTES)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .busy         (busy),
    .ctl_doorbell (ctl_doorbell),
    .ctl_done     (ctl_done),
    .host_irq     (host_irq),
    .ctl_cmd      (ctl_cmd),
    .ctl_wbuf     (ctl_wbuf)
);

// File: tb/sim_hc_mailbox.sv
module sim_hc_mailbox;

    localparam int NB = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          hst_valid = 1'b0, hst_write = 1'b0;
    logic [7:0]    hst_addr = '0;
    logic [3:0]    hst_be = '0;
    logic [31:0]   hst_wdata = '0;
    logic [31:0]   hst_rdata;
    logic          host_irq, ctl_doorbell;
    logic [31:0]   ctl_cmd;
    logic [NB*8-1:0] ctl_wbuf;
    logic          ctl_done = 1'b0, ctl_fail = 1'b0;
    logic [7:0]    ctl_ecode = '0, ctl_initiator = '0;
    logic          ctl_resp_we = 1'b0;
    logic [1:0]    ctl_resp_idx = '0;
    logic [31:0]   ctl_resp_data = '0;

    int n_chk = 0;
    int n_bad = 0;
    bit live = 1'b0;

    always #10ns clk = ~clk;

    hc_mailbox u0 (.*);

    // behavioural reference
    bit       m_busy, m_err, m_ovr, m_ioc, m_bell, m_irq;
    int       m_sub, m_init, m_ecode;
    bit [31:0] m_cmd, m_rd;
    byte unsigned m_wb [NB];
    byte unsigned m_rb [NB];

    function automatic bit [31:0] m_status();
        return (m_ecode << 16) | (m_init << 8) | (m_sub << 4)
             | (int'(m_ovr) << 2) | (int'(m_err) << 1) | int'(m_busy);
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_busy = 0; m_err = 0; m_ovr = 0; m_ioc = 0; m_bell = 0; m_irq = 0;
            m_sub = 0; m_init = 0; m_ecode = 0; m_cmd = 0; m_rd = 0;
            foreach (m_wb[i]) begin m_wb[i] = 0; m_rb[i] = 0; end
        end else begin
            bit was_busy;
            int a;
            was_busy = m_busy;
            a = int'(hst_addr);
            m_bell = 0; m_irq = 0;
            if (hst_valid && !hst_write) begin
                m_rd = 0;
                if (a >= 4 && a < 8) m_rd = m_status();
                else if (a >= 'h90 && a < 'h90 + NB) begin
                    int n;
                    n = a - 'h90;
                    for (int j = 0; j < 4 - (n % 4); j++)
                        m_rd[8*j +: 8] = m_rb[n + j];
                end
            end
            if (ctl_done && was_busy) begin
                m_busy = 0; m_err = ctl_fail; m_ecode = ctl_ecode;
                m_init = ctl_initiator; m_irq = m_ioc;
            end
            if (hst_valid && hst_write && a < 4) begin
                if (was_busy) m_ovr = 1;
                else begin
                    m_busy = 1; m_bell = 1; m_cmd = hst_wdata;
                    m_ioc = hst_wdata[8]; m_sub = int'(hst_wdata[15:12]);
                    m_err = 0; m_ecode = 0;
                end
            end
            if (hst_valid && hst_write && a >= 'h80 && a < 'h80 + NB && !was_busy)
                for (int b = 0; b < 4; b++)
                    if (hst_be[b]) m_wb[((a - 'h80) / 4) * 4 + b] = hst_wdata[8*b +: 8];
            if (ctl_resp_we)
                for (int b = 0; b < 4; b++)
                    m_rb[int'(ctl_resp_idx) * 4 + b] = ctl_resp_data[8*b +: 8];
        end
    end

    task automatic chk(bit ok, string req, logic [127:0] act, logic [127:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    // compare against the reference on every clock
    always @(negedge clk) begin
        if (live) begin
            logic [NB*8-1:0] ewb;
            for (int k = 0; k < NB; k++) ewb[8*k +: 8] = m_wb[k];
            chk(hst_rdata === m_rd, "R10 rdata", 128'(hst_rdata), 128'(m_rd));
            chk(ctl_doorbell === m_bell, "R2 doorbell", 128'(ctl_doorbell), 128'(m_bell));
            chk(ctl_cmd === m_cmd, "R2 cmd", 128'(ctl_cmd), 128'(m_cmd));
            chk(host_irq === m_irq, "R6 irq", 128'(host_irq), 128'(m_irq));
            chk(ctl_wbuf === ewb, "R7 wbuf", 128'(ctl_wbuf), 128'(ewb));
        end
    end

    task automatic hwr(input logic [7:0] a, input logic [31:0] d, input logic [3:0] be);
        @(negedge clk);
        hst_valid = 1; hst_write = 1; hst_addr = a; hst_wdata = d; hst_be = be;
        @(negedge clk);
        hst_valid = 0; hst_write = 0;
    endtask

    task automatic hrd(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        hst_valid = 1; hst_write = 0; hst_addr = a;
        @(negedge clk);
        hst_valid = 0;
        d = hst_rdata;
    endtask

    task automatic cfin(input bit f, input logic [7:0] code, input logic [7:0] ini,
                        output logic irq);
        @(negedge clk);
        ctl_done = 1; ctl_fail = f; ctl_ecode = code; ctl_initiator = ini;
        @(negedge clk);
        ctl_done = 0;
        irq = host_irq;
    endtask

    task automatic cresp(input logic [1:0] i, input logic [31:0] d);
        @(negedge clk);
        ctl_resp_we = 1; ctl_resp_idx = i; ctl_resp_data = d;
        @(negedge clk);
        ctl_resp_we = 0;
    endtask

    task automatic finish_run();
        $display("  %0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    endtask

    initial begin
        #(200000 * 20ns);
        n_chk++; n_bad++;
        $display("FAIL watchdog expired actual=running expected=done");
        finish_run();
    end

    initial begin
        logic [31:0] r;
        logic i;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        live = 1;
        // R1 reset state
        chk(ctl_doorbell === 0 && host_irq === 0, "R1 pulses", 128'({ctl_doorbell, host_irq}), 0);
        chk(ctl_cmd === 0 && ctl_wbuf === 0, "R1 cmd/wbuf", 128'(ctl_wbuf), 0);
        hrd(8'h04, r); chk(r === 0, "R1 status", 128'(r), 0);
        // R7 payload with byte enables
        hwr(8'h80, 32'h44332211, 4'hf);
        hwr(8'h84, 32'hAABBCCDD, 4'b0101);
        chk(ctl_wbuf[63:0] === 64'h00BB00DD_44332211, "R7 byte lanes",
            128'(ctl_wbuf[63:0]), 128'(64'h00BB00DD_44332211));
        // R9 write-only regions read zero
        hrd(8'h80, r); chk(r === 0, "R9 wbuf read", 128'(r), 0);
        hrd(8'h00, r); chk(r === 0, "R9 cmd read", 128'(r), 0);
        hrd(8'h40, r); chk(r === 0, "R9 unmapped read", 128'(r), 0);
        // R2 accept with ioc, sub id 5
        hwr(8'h00, 32'h000351F8, 4'h0);
        chk(ctl_cmd === 32'h000351F8 && ctl_doorbell === 1, "R2 accept",
            128'(ctl_cmd), 128'(32'h000351F8));
        hrd(8'h04, r); chk(r === 32'h00000051, "R5 busy status", 128'(r), 128'(32'h51));
        // R3 overrun
        hwr(8'h00, 32'h0000F0AA, 4'hf);
        chk(ctl_cmd === 32'h000351F8, "R3 cmd kept", 128'(ctl_cmd), 128'(32'h000351F8));
        hrd(8'h04, r); chk(r === 32'h00000055, "R3 overrun bit", 128'(r), 128'(32'h55));
        // R7 payload frozen while busy
        hwr(8'h88, 32'hFFFFFFFF, 4'hf);
        chk(ctl_wbuf[95:64] === 0, "R7 busy drop", 128'(ctl_wbuf[95:64]), 0);
        // R8 response, R4/R6 completion with failure
        cresp(2'd0, 32'hDDCCBBAA);
        cresp(2'd3, 32'h87654321);
        cfin(1, 8'h3C, 8'h7A, i);
        chk(i === 1, "R6 irq with ioc", 128'(i), 1);
        hrd(8'h04, r); chk(r === 32'h003C7A56, "R4 completion status", 128'(r), 128'(32'h003C7A56));
        hrd(8'h90, r); chk(r === 32'hDDCCBBAA, "R8 word read", 128'(r), 128'(32'hDDCCBBAA));
        hrd(8'h92, r); chk(r === 32'h0000DDCC, "R8 offset 2", 128'(r), 128'(32'hDDCC));
        hrd(8'h9F, r); chk(r === 32'h00000087, "R8 last byte", 128'(r), 128'(32'h87));
        // R9 writes to read-only locations
        hwr(8'h04, 32'hFFFFFFFF, 4'hf);
        hwr(8'h90, 32'h0, 4'hf);
        hrd(8'h04, r); chk(r === 32'h003C7A56, "R9 status write", 128'(r), 128'(32'h003C7A56));
        hrd(8'h90, r); chk(r === 32'hDDCCBBAA, "R9 rbuf write", 128'(r), 128'(32'hDDCCBBAA));
        // R4 done while idle ignored
        cfin(0, 8'h11, 8'h22, i);
        chk(i === 0, "R4 idle done irq", 128'(i), 0);
        hrd(8'h04, r); chk(r === 32'h003C7A56, "R4 idle done", 128'(r), 128'(32'h003C7A56));
        // R5 new command clears error, keeps initiator; R6 no ioc
        hwr(8'h00, 32'h0010A0EF, 4'hf);
        hrd(8'h04, r); chk(r === 32'h00007AA5, "R5 error cleared", 128'(r), 128'(32'h00007AA5));
        hwr(8'h8C, 32'h01020304, 4'hf);
        chk(ctl_wbuf[127:96] === 0, "R7 busy drop 2", 128'(ctl_wbuf[127:96]), 0);
        cfin(0, 8'h00, 8'h09, i);
        chk(i === 0, "R6 no irq without ioc", 128'(i), 0);
        hrd(8'h04, r); chk(r === 32'h000009A4, "R4 clean done", 128'(r), 128'(32'h000009A4));
        // R10 read data holds
        repeat (3) @(negedge clk);
        chk(hst_rdata === 32'h000009A4, "R10 hold", 128'(hst_rdata), 128'(32'h000009A4));
        hwr(8'h8C, 32'h01020304, 4'b1000);
        chk(ctl_wbuf[127:96] === 32'h01000000, "R7 idle lane 3",
            128'(ctl_wbuf[127:96]), 128'(32'h01000000));
        @(negedge clk);
        live = 0;
        finish_run();
    end

endmodule